// File: doc/BRIEF.md
# Iterative 3x3 Rank-Order Selector

This block takes the nine samples of one 3x3 pixel window and returns the sample that holds a chosen rank. A start pulse loads all nine samples into hold registers. One two-layer array of min/max exchange nodes then runs over the held values once per clock, for five clocks, and leaves them in ascending order. The first layer exchanges the pairs that start on an even index and the second layer the pairs that start on an odd index, so five passes give ten odd-even transposition phases.

After the sort a rank multiplexer picks one of the nine sorted values. A direction input sets whether rank 0 is the smallest value (direct order) or the largest (inverse order). Rank 4 gives the median filter, and the two end ranks give erosion and dilation. The rank and direction controls act on the stored sorted array directly, so one sort can be read at any number of ranks.

Top module: `rank_select3x3`

## Requirements
- R1: After reset `validOut` is 0 and `pixelOut` is 0.
- R2: A start pulse while the block is idle loads the nine samples and drives `validOut` low at the next clock edge. Sample i sits in `samplesIn[i*DATA_W +: DATA_W]`.
- R3: `validOut` rises at the fifth rising clock edge after the edge that accepted the start, and stays high until the next accepted start.
- R4: With `dirSel`=0 (direct), rank code r (0..8) gives the r-th smallest sample. Rank 0 is the minimum and rank 8 is the maximum.
- R5: With `dirSel`=1 (inverse), rank code r (0..8) gives the r-th largest sample. Rank 0 is the maximum and rank 8 is the minimum.
- R6: Rank code 4 gives the median of the nine samples in either direction.
- R7: Rank codes 9 to 15 act as rank 8.
- R8: A start pulse that arrives while a sort is in progress is ignored. Valid timing and the result come from the window that was accepted.
- R9: When samples are equal, each value is kept as many times as it occurs. A window of identical values returns that value at every rank.
- R10: While `validOut` is high, `pixelOut` follows changes of `rankSel` and `dirSel` in the same cycle, without a new sort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Start pulse that captures a window |
| samplesIn | input | 9*DATA_W | Nine window samples, sample i at bits i*DATA_W and up |
| rankSel | input | 4 | Requested rank code |
| dirSel | input | 1 | 0 = direct (ascending), 1 = inverse (descending) |
| validOut | output | 1 | Sorted result available |
| pixelOut | output | DATA_W | Sample of the selected rank |

## Verification
On every cycle the assertions check four things. The held array is in ascending order whenever `validOut` is high. Valid rises only at the fifth edge after an accepted start. Valid is low during a sort. The output holds steady while valid and the controls are unchanged. Only the bench scenarios can show which value each rank and direction returns, how out-of-range codes saturate, how duplicate and uniform windows behave, and that a start during a sort leaves the result unchanged. The bench computes each of these by counting the samples that are smaller than or equal to the result.

// File: rtl/rank_pkg.sv
package rank_pkg;
  localparam int NUM_TAPS = 9;
  localparam int NUM_PASSES = 5;
  localparam int RANK_W = 4;

  typedef struct packed {
    logic load;
    logic step;
  } sortStrobes_t;
endpackage

// File: rtl/minmax_node.sv
module minmax_node #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] bIn,
  output logic [DATA_W-1:0] loOut,
  output logic [DATA_W-1:0] hiOut
);
  logic swap;
  assign swap  = aIn > bIn;
  assign loOut = swap ? bIn : aIn;
  assign hiOut = swap ? aIn : bIn;
endmodule

// File: rtl/rank_ctrl.sv
module rank_ctrl
  import rank_pkg::*;
#(
  parameter int PASSES = NUM_PASSES
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startIn,
  output sortStrobes_t strobes,
  output logic         validOut
);
  localparam int CNT_W = $clog2(PASSES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PASSES - 1);

  logic             busyQ;
  logic [CNT_W-1:0] passCnt;

  always_comb begin
    strobes.load = startIn && !busyQ;
    strobes.step = busyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      passCnt  <= '0;
      validOut <= 1'b0;
    end else if (strobes.load) begin
      busyQ    <= 1'b1;
      passCnt  <= '0;
      validOut <= 1'b0;
    end else if (strobes.step) begin
      passCnt <= passCnt + 1'b1;
      if (passCnt == LAST) begin
        busyQ    <= 1'b0;
        validOut <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rank_datapath.sv
module rank_datapath
  import rank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  sortStrobes_t               strobes,
  input  logic [NUM_TAPS*DATA_W-1:0] samplesIn,
  output logic [NUM_TAPS*DATA_W-1:0] sortedFlat
);
  localparam int PAIRS = NUM_TAPS / 2;

  logic [DATA_W-1:0] holdQ  [NUM_TAPS];
  logic [DATA_W-1:0] layerA [NUM_TAPS];
  logic [DATA_W-1:0] layerB [NUM_TAPS];

  // first layer: pairs starting on even index, last tap passes through
  genvar k;
  generate
    for (k = 0; k < PAIRS; k++) begin : g_even
      minmax_node #(.DATA_W(DATA_W)) i_node (
        .aIn(holdQ[2*k]), .bIn(holdQ[2*k+1]),
        .loOut(layerA[2*k]), .hiOut(layerA[2*k+1]));
    end
    if (NUM_TAPS % 2 == 1) begin : g_evenTail
      assign layerA[NUM_TAPS-1] = holdQ[NUM_TAPS-1];
    end
  endgenerate

  // second layer: pairs starting on odd index, tap 0 passes through
  assign layerB[0] = layerA[0];
  generate
    for (k = 0; k < (NUM_TAPS - 1) / 2; k++) begin : g_odd
      minmax_node #(.DATA_W(DATA_W)) i_node (
        .aIn(layerA[2*k+1]), .bIn(layerA[2*k+2]),
        .loOut(layerB[2*k+1]), .hiOut(layerB[2*k+2]));
    end
    if (NUM_TAPS % 2 == 0) begin : g_oddTail
      assign layerB[NUM_TAPS-1] = layerA[NUM_TAPS-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_TAPS; i++) holdQ[i] <= '0;
    end else if (strobes.load) begin
      for (int i = 0; i < NUM_TAPS; i++) holdQ[i] <= samplesIn[i*DATA_W +: DATA_W];
    end else if (strobes.step) begin
      for (int i = 0; i < NUM_TAPS; i++) holdQ[i] <= layerB[i];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_TAPS; i++) sortedFlat[i*DATA_W +: DATA_W] = holdQ[i];
  end
endmodule

// File: rtl/rank_select3x3.sv
module rank_select3x3
  import rank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       startIn,
  input  logic [NUM_TAPS*DATA_W-1:0] samplesIn,
  input  logic [RANK_W-1:0]          rankSel,
  input  logic                       dirSel,
  output logic                       validOut,
  output logic [DATA_W-1:0]          pixelOut
);
  localparam logic [RANK_W-1:0] TOP_RANK = RANK_W'(NUM_TAPS - 1);

  sortStrobes_t              strobes;
  logic [NUM_TAPS*DATA_W-1:0] sortedFlat;
  logic [RANK_W-1:0]          clampRank;
  logic [RANK_W-1:0]          tapIdx;

  rank_ctrl #(.PASSES(NUM_PASSES)) i_ctrl (
    .clk(clk), .rstN(rstN), .startIn(startIn),
    .strobes(strobes), .validOut(validOut));

  rank_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .samplesIn(samplesIn), .sortedFlat(sortedFlat));

  always_comb begin
    clampRank = (rankSel > TOP_RANK) ? TOP_RANK : rankSel;
    tapIdx    = dirSel ? (TOP_RANK - clampRank) : clampRank;
    pixelOut  = sortedFlat[tapIdx*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/rank_select_chk.sv
module rank_select_chk
  import rank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       startIn,
  input logic [RANK_W-1:0]          rankSel,
  input logic                       dirSel,
  input logic                       validOut,
  input logic [DATA_W-1:0]          pixelOut,
  input logic [NUM_TAPS*DATA_W-1:0] sortedFlat
);
  logic       busyM;
  logic [3:0] cntM;
  logic       ascOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyM <= 1'b0;
      cntM  <= '0;
    end else if (startIn && !busyM) begin
      busyM <= 1'b1;
      cntM  <= '0;
    end else if (busyM) begin
      cntM <= cntM + 1'b1;
      if (cntM == 4'(NUM_PASSES - 1)) busyM <= 1'b0;
    end
  end

  always_comb begin
    ascOk = 1'b1;
    for (int i = 0; i < NUM_TAPS - 1; i++)
      if (sortedFlat[i*DATA_W +: DATA_W] > sortedFlat[(i+1)*DATA_W +: DATA_W]) ascOk = 1'b0;
  end

  // R3: valid rises only at the fifth edge after an accepted start
  a_r3_valid_timing: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validOut) |-> (cntM == 4'(NUM_PASSES) && !busyM));

  // R2: valid stays low while a sort runs
  a_r2_low_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busyM |-> !validOut);

  // R4: held array is in ascending order whenever valid
  a_r4_sorted: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> ascOk);

  // R10: output steady while valid and controls unchanged
  a_r10_stable_out: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && $past(validOut) && $stable(rankSel) && $stable(dirSel)) |-> $stable(pixelOut));
endmodule

bind rank_select3x3 rank_select_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .startIn(startIn), .rankSel(rankSel),
  .dirSel(dirSel), .validOut(validOut), .pixelOut(pixelOut),
  .sortedFlat(sortedFlat));

// File: tb/test_rank_select3x3.sv
module test_rank_select3x3;
  localparam int W = 8;
  localparam int N = 9;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           startIn = 1'b0;
  logic [N*W-1:0] samplesIn = '0;
  logic [3:0]     rankSel = '0;
  logic           dirSel = 1'b0;
  logic           validOut;
  logic [W-1:0]   pixelOut;

  int checks = 0;
  int errors = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  rank_select3x3 #(.DATA_W(W)) i_rank_select3x3 (
    .clk(clk), .rstN(rstN), .startIn(startIn), .samplesIn(samplesIn),
    .rankSel(rankSel), .dirSel(dirSel), .validOut(validOut), .pixelOut(pixelOut));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // r-th smallest by counting: value v where #less <= r < #lessOrEqual
  function automatic logic [W-1:0] rankValue(input logic [N*W-1:0] win, input int r);
    logic [W-1:0] res = '0;
    for (int i = 0; i < N; i++) begin
      int lt = 0;
      int le = 0;
      for (int j = 0; j < N; j++) begin
        if (win[j*W +: W] < win[i*W +: W]) lt++;
        if (win[j*W +: W] <= win[i*W +: W]) le++;
      end
      if (lt <= r && r < le) res = win[i*W +: W];
    end
    return res;
  endfunction

  function automatic logic [W-1:0] expectOut(input logic [N*W-1:0] win, input int code, input bit dir);
    int r = (code > 8) ? 8 : code;
    return dir ? rankValue(win, 8 - r) : rankValue(win, r);
  endfunction

  // runs one sort; optional extra start mid-sort with another window
  task automatic runSort(input logic [N*W-1:0] win, input bit intrude, input logic [N*W-1:0] other);
    @(negedge clk);
    samplesIn = win;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    check("R2 valid low after start", validOut, 0);
    for (int n = 2; n <= 5; n++) begin
      if (intrude && n == 3) begin
        samplesIn = other;
        startIn = 1'b1;
      end
      @(negedge clk);
      startIn = 1'b0;
      check(intrude ? "R8 valid low while busy" : "R3 valid low while busy", validOut, 0);
    end
    @(negedge clk);
    check(intrude ? "R8 valid timing" : "R3 valid at fifth edge", validOut, 1);
  endtask

  task automatic sweepRanks(input logic [N*W-1:0] win, input string req);
    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 16; c++) begin
        rankSel = 4'(c);
        dirSel = d[0];
        #1;
        if (c > 8) check("R7 saturated code", pixelOut, expectOut(win, c, d[0]));
        else if (c == 4) check("R6 median", pixelOut, expectOut(win, c, d[0]));
        else if (d == 0) check({req, " R4 direct"}, pixelOut, expectOut(win, c, 0));
        else check({req, " R5 inverse"}, pixelOut, expectOut(win, c, 1));
      end
    end
    check("R10 valid holds during sweep", validOut, 1);
  endtask

  function automatic logic [N*W-1:0] randWin();
    logic [N*W-1:0] w;
    for (int i = 0; i < N; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      w[i*W +: W] = lfsr[7:0];
    end
    return w;
  endfunction

  initial begin
    logic [N*W-1:0] win;
    logic [N*W-1:0] alt;
    #1;
    check("R1 reset valid", validOut, 0);
    check("R1 reset out", pixelOut, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 valid after reset", validOut, 0);

    for (int i = 0; i < N; i++) win[i*W +: W] = W'(10 * i + 3);
    runSort(win, 0, '0); sweepRanks(win, "ascending");
    for (int i = 0; i < N; i++) win[i*W +: W] = W'(250 - 20 * i);
    runSort(win, 0, '0); sweepRanks(win, "descending");
    for (int i = 0; i < N; i++) win[i*W +: W] = 8'h5A;
    runSort(win, 0, '0);
    for (int c = 0; c < 9; c++) begin
      rankSel = 4'(c); dirSel = c[0]; #1;
      check("R9 uniform window", pixelOut, 8'h5A);
    end
    for (int i = 0; i < N; i++) win[i*W +: W] = (i % 3 == 0) ? 8'd7 : ((i % 3 == 1) ? 8'd255 : 8'd0);
    runSort(win, 0, '0); sweepRanks(win, "R9 duplicates");
    for (int t = 0; t < 40; t++) begin
      win = randWin();
      runSort(win, 0, '0); sweepRanks(win, "random");
    end
    win = randWin();
    alt = '0;
    runSort(win, 1, alt); sweepRanks(win, "R8 busy start ignored");
    // valid stays high until next accepted start
    repeat (4) @(negedge clk);
    check("R3 valid held", validOut, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule